// File: doc/BRIEF.md
# Insulation Measurement Switch Sequencer

This block runs the timing of a two-phase insulation-resistance measurement. It drives one enable for a switch that ties the measurement bridge to the positive rail and one for a switch that ties it to the negative rail. After a one-time warm-up interval that follows reset, each start pulse runs a fixed sequence:

- Close the positive switch and wait for the analog input to settle.
- Read the isolation-voltage channel and the bus-voltage channel alternately through a request/valid handshake to an external converter.
- Open the positive switch and wait a break-before-make gap.
- Close the negative switch and repeat the settle wait and the readings.

The block sums each channel in each phase, divides each sum by the sample count, and then presents four averages together with a one-cycle done pulse. The resistance calculation is left to the consumer.

The settle interval and the break-before-make gap are held in registers that can be written at run time, because heavier capacitive loading on the measured network needs longer settling. Both registers take their reset values from microsecond parameters and the clock frequency. An abort input returns the block to idle at once, with both switches open.

Top module: `iso_meas_seq`

## Requirements
- R1: After reset both enables, the conversion request and done are low. For the first INIT_US×CLK_HZ/10^6 cycles after reset release, start is ignored.
- R2: An accepted start raises the positive enable in the next cycle. The first conversion request comes after the positive enable has been high for exactly S cycles, where S is the settle register value and a value of 0 acts as 1. The negative phase obeys the same rule.
- R3: The settle and dead-time registers reset to SETTLE_US and DEAD_US worth of clock cycles. A write strobe loads a new value, and each interval uses the value held in the cycle in which that interval starts. A write during the gap therefore changes the negative settle wait of the same run.
- R4: The positive enable falls in the cycle after the last positive-phase sample is accepted. The negative enable rises after exactly D cycles with both enables low, where D is the dead-time register value and 0 acts as 1.
- R5: The two switch enables are never high in the same cycle.
- R6: Each phase issues 2×NSAMP requests, and one switch enable is high during every one of them. The channel select is 0 (isolation voltage) on the first request and alternates with 1 (bus voltage) after that.
- R7: At most one request is outstanding. No new request is issued until valid has answered the previous one, and a valid with no request outstanding is ignored.
- R8: Each of the four outputs equals the floor of its channel's phase sum divided by NSAMP. This holds with every sample at full scale.
- R9: done is a single-cycle pulse. It comes one cycle after the negative enable falls, and the four outputs change only in a done cycle.
- R10: A start while a run is in progress is ignored, and the run completes unchanged.
- R11: An abort outside idle and warm-up lowers both enables in the next cycle and cancels the run with no done pulse. The averages are left unchanged, and the block then accepts a new start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a measurement run (idle only) |
| abort | input | 1 | Cancel the run and open both switches |
| settle_wr | input | 1 | Write strobe for the settle register |
| settle_val | input | CNT_W | New settle interval in cycles |
| dead_wr | input | 1 | Write strobe for the dead-time register |
| dead_val | input | CNT_W | New break-before-make gap in cycles |
| sw_pos_en | output | 1 | Positive-side switch enable |
| sw_neg_en | output | 1 | Negative-side switch enable |
| adc_req | output | 1 | One-cycle conversion request |
| adc_ch | output | 1 | Channel select: 0 isolation voltage, 1 bus voltage |
| adc_valid | input | 1 | Conversion result valid |
| adc_data | input | DATA_W | Conversion result |
| done | output | 1 | One-cycle pulse: averages updated |
| avg_iso_pos | output | DATA_W | Isolation-voltage average, positive phase |
| avg_bus_pos | output | DATA_W | Bus-voltage average, positive phase |
| avg_iso_neg | output | DATA_W | Isolation-voltage average, negative phase |
| avg_bus_neg | output | DATA_W | Bus-voltage average, negative phase |

## Verification
The bench sets CLK_HZ to 1 MHz and INIT_US to 200. With these values the reset defaults become 500 settle cycles and 400 gap cycles, and warm-up lasts 200 cycles, so the default run and its exact interval counts fit inside a short run. NSAMP stays at 20 and DATA_W at 16, so the full-scale case drives the widest phase sum through the reciprocal-multiply division. Register writes of 0 and of small values reach the "0 acts as 1" boundary, and a write during the gap shows that the negative settle wait picks up the new value.

// File: rtl/iso_seq_pkg.sv
package iso_seq_pkg;

  typedef enum logic [2:0] {
    ST_INIT,
    ST_IDLE,
    ST_SETTLE_P,
    ST_SAMP_P,
    ST_DEAD,
    ST_SETTLE_N,
    ST_SAMP_N,
    ST_FINISH
  } seq_state_t;

  // microseconds to clock cycles, 64-bit so large clocks do not overflow
  function automatic longint us_to_cyc(input longint hz, input longint us);
    return (hz * us) / 64'd1_000_000;
  endfunction

endpackage

// File: rtl/iso_seq_timer.sv
module iso_seq_timer #(
  parameter int             CNT_W   = 24,
  parameter logic [CNT_W-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)              cnt_q <= RST_VAL;
    else if (load)           cnt_q <= load_val;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  // last cycle of an interval; a loaded 0 expires at once, like 1
  assign expired = (cnt_q <= CNT_W'(1));

  assert_count_down_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && cnt_q > CNT_W'(1)) |=> (cnt_q == $past(cnt_q) - CNT_W'(1)))
    else $error("interval counter skipped a step");

endmodule

// File: rtl/iso_seq_avg.sv
module iso_seq_avg #(
  parameter int DATA_W = 16,
  parameter int NSAMP  = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              add,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] avg
);

  localparam int     SUM_W = DATA_W + $clog2(NSAMP);
  localparam int     SH    = SUM_W + $clog2(NSAMP);
  localparam int     PW    = SUM_W + SH + 1;
  localparam longint MUL_L = ((64'd1 << SH) + longint'(NSAMP) - 1) / longint'(NSAMP);

  logic [SUM_W-1:0] sum_q;

  // floor(s / NSAMP) by reciprocal multiply; exact for every s below 2**SUM_W
  function automatic logic [DATA_W-1:0] div_by_n(input logic [SUM_W-1:0] s);
    logic [PW-1:0] p;
    p = PW'(s) * PW'(MUL_L);
    return DATA_W'(p >> SH);
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n)    sum_q <= '0;
    else if (clr)  sum_q <= '0;
    else if (add)  sum_q <= sum_q + SUM_W'(din);
  end

  assign avg = div_by_n(sum_q);

  assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (add && !clr) |=> (sum_q >= $past(sum_q)))
    else $error("phase sum wrapped");

endmodule

// File: rtl/iso_meas_seq.sv
module iso_meas_seq
  import iso_seq_pkg::*;
#(
  parameter longint CLK_HZ    = 125_000_000,
  parameter int     INIT_US   = 3000,
  parameter int     SETTLE_US = 500,
  parameter int     DEAD_US   = 400,
  parameter int     NSAMP     = 20,
  parameter int     DATA_W    = 16,
  parameter int     CNT_W     = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              abort,
  input  logic              settle_wr,
  input  logic [CNT_W-1:0]  settle_val,
  input  logic              dead_wr,
  input  logic [CNT_W-1:0]  dead_val,
  output logic              sw_pos_en,
  output logic              sw_neg_en,
  output logic              adc_req,
  output logic              adc_ch,
  input  logic              adc_valid,
  input  logic [DATA_W-1:0] adc_data,
  output logic              done,
  output logic [DATA_W-1:0] avg_iso_pos,
  output logic [DATA_W-1:0] avg_bus_pos,
  output logic [DATA_W-1:0] avg_iso_neg,
  output logic [DATA_W-1:0] avg_bus_neg
);

  localparam logic [CNT_W-1:0] INIT_CYC   = CNT_W'(us_to_cyc(CLK_HZ, longint'(INIT_US)));
  localparam logic [CNT_W-1:0] SETTLE_DEF = CNT_W'(us_to_cyc(CLK_HZ, longint'(SETTLE_US)));
  localparam logic [CNT_W-1:0] DEAD_DEF   = CNT_W'(us_to_cyc(CLK_HZ, longint'(DEAD_US)));
  localparam int               CONV_TOT   = 2 * NSAMP;
  localparam int               CONV_W     = $clog2(CONV_TOT);
  localparam logic [CONV_W-1:0] CONV_LAST = CONV_W'(CONV_TOT - 1);

  seq_state_t        st_q, st_nxt;
  logic [CNT_W-1:0]  settle_q, dead_q, tmr_val;
  logic              tmr_load, tmr_exp;
  logic              pend_q, done_q;
  logic [CONV_W-1:0] conv_q;
  logic [DATA_W-1:0] avg_w [4];
  logic [DATA_W-1:0] res_q [4];

  // named events used by the logic below and by the assertions
  logic in_samp, in_settle, phase_neg, take, last_take, abort_hit, cycle_go;

  assign in_samp   = (st_q == ST_SAMP_P) || (st_q == ST_SAMP_N);
  assign in_settle = (st_q == ST_SETTLE_P) || (st_q == ST_SETTLE_N);
  assign phase_neg = (st_q == ST_SAMP_N);
  assign take      = pend_q && adc_valid && in_samp;
  assign last_take = take && (conv_q == CONV_LAST);
  assign abort_hit = abort && (st_q != ST_INIT) && (st_q != ST_IDLE);

  // settle and break-before-make registers
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      settle_q <= SETTLE_DEF;
      dead_q   <= DEAD_DEF;
    end else begin
      if (settle_wr) settle_q <= settle_val;
      if (dead_wr)   dead_q   <= dead_val;
    end
  end

  iso_seq_timer #(.CNT_W(CNT_W), .RST_VAL(INIT_CYC)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .expired  (tmr_exp)
  );

  always_comb begin
    st_nxt   = st_q;
    tmr_load = 1'b0;
    tmr_val  = settle_q;
    cycle_go = 1'b0;
    case (st_q)
      ST_INIT:     if (tmr_exp) st_nxt = ST_IDLE;
      ST_IDLE:     if (start) begin
                     st_nxt = ST_SETTLE_P; tmr_load = 1'b1; cycle_go = 1'b1;
                   end
      ST_SETTLE_P: if (tmr_exp) st_nxt = ST_SAMP_P;
      ST_SAMP_P:   if (last_take) begin
                     st_nxt = ST_DEAD; tmr_load = 1'b1; tmr_val = dead_q;
                   end
      ST_DEAD:     if (tmr_exp) begin
                     st_nxt = ST_SETTLE_N; tmr_load = 1'b1;
                   end
      ST_SETTLE_N: if (tmr_exp) st_nxt = ST_SAMP_N;
      ST_SAMP_N:   if (last_take) st_nxt = ST_FINISH;
      ST_FINISH:   st_nxt = ST_IDLE;
      default:     st_nxt = ST_IDLE;
    endcase
    if (abort_hit) begin
      st_nxt   = ST_IDLE;
      tmr_load = 1'b0;
      cycle_go = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= ST_INIT;
      pend_q <= 1'b0;
      conv_q <= '0;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_nxt;
      done_q <= (st_q == ST_FINISH) && !abort_hit;
      if (abort_hit)     pend_q <= 1'b0;
      else if (adc_req)  pend_q <= 1'b1;
      else if (take)     pend_q <= 1'b0;
      if (abort_hit || (in_settle && tmr_exp)) conv_q <= '0;
      else if (take)                           conv_q <= conv_q + 1'b1;
    end
  end

  assign sw_pos_en = (st_q == ST_SETTLE_P) || (st_q == ST_SAMP_P);
  assign sw_neg_en = (st_q == ST_SETTLE_N) || (st_q == ST_SAMP_N);
  assign adc_req   = in_samp && !pend_q;
  assign adc_ch    = conv_q[0];

  // index = {phase, channel}: 0 iso/pos, 1 bus/pos, 2 iso/neg, 3 bus/neg
  for (genvar gi = 0; gi < 4; gi++) begin : g_avg
    localparam bit PH = (gi / 2) == 1;
    localparam bit CH = (gi % 2) == 1;
    iso_seq_avg #(.DATA_W(DATA_W), .NSAMP(NSAMP)) u_avg (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (cycle_go),
      .add   (take && (phase_neg == PH) && (adc_ch == CH)),
      .din   (adc_data),
      .avg   (avg_w[gi])
    );
    always_ff @(posedge clk) begin
      if (!rst_n)                                  res_q[gi] <= '0;
      else if ((st_q == ST_FINISH) && !abort_hit)  res_q[gi] <= avg_w[gi];
    end
  end

  assign done        = done_q;
  assign avg_iso_pos = res_q[0];
  assign avg_bus_pos = res_q[1];
  assign avg_iso_neg = res_q[2];
  assign avg_bus_neg = res_q[3];

  assert_exclusive_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(sw_pos_en && sw_neg_en))
    else $error("both switch enables high");

  assert_gap_elapsed_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sw_neg_en) |-> $past(tmr_exp))
    else $error("negative switch closed before the gap ran out");

  assert_one_outstanding_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && !adc_valid) |=> !adc_req)
    else $error("request issued while one was outstanding");

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done)
    else $error("done longer than one cycle");

  assert_results_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(avg_iso_pos) && $stable(avg_bus_pos) &&
               $stable(avg_iso_neg) && $stable(avg_bus_neg)))
    else $error("averages changed outside a done cycle");

  assert_abort_opens_R11: assert property (@(posedge clk) disable iff (!rst_n)
    abort_hit |=> (!sw_pos_en && !sw_neg_en && !done))
    else $error("abort did not open both switches");

endmodule

// File: tb/iso_meas_seq_test.sv
module iso_meas_seq_test;

  localparam int DW = 16;
  localparam int CW = 24;
  localparam int NS = 20;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0, abort = 1'b0;
  logic          settle_wr = 1'b0, dead_wr = 1'b0;
  logic [CW-1:0] settle_val = '0, dead_val = '0;
  logic          sw_pos_en, sw_neg_en, adc_req, adc_ch, done;
  logic          adc_valid = 1'b0;
  logic [DW-1:0] adc_data = '0;
  logic [DW-1:0] avg_iso_pos, avg_bus_pos, avg_iso_neg, avg_bus_neg;

  always #4 clk = ~clk;  // 125 MHz

  iso_meas_seq #(
    .CLK_HZ(64'd1_000_000), .INIT_US(200), .SETTLE_US(500), .DEAD_US(400),
    .NSAMP(NS), .DATA_W(DW), .CNT_W(CW)
  ) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .abort(abort),
    .settle_wr(settle_wr), .settle_val(settle_val),
    .dead_wr(dead_wr), .dead_val(dead_val),
    .sw_pos_en(sw_pos_en), .sw_neg_en(sw_neg_en),
    .adc_req(adc_req), .adc_ch(adc_ch),
    .adc_valid(adc_valid), .adc_data(adc_data),
    .done(done),
    .avg_iso_pos(avg_iso_pos), .avg_bus_pos(avg_bus_pos),
    .avg_iso_neg(avg_iso_neg), .avg_bus_neg(avg_bus_neg)
  );

  int     n_chk = 0, n_bad = 0;
  int     data_mode = 0;
  longint bsum [4];
  int     bcnt [4];
  int     rq   [2];
  int     meas_sp, meas_sn, meas_dead;
  int     done_seen = 0;
  int     cur_settle = 500, cur_dead = 400;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int eff(input int v);
    return (v == 0) ? 1 : v;
  endfunction

  function automatic logic [DW-1:0] gen_data();
    case (data_mode)
      1:       return 16'hFFFF;
      2:       return 16'h0000;
      3:       return DW'($urandom_range(0, 15));
      default: return DW'($urandom);
    endcase
  endfunction

  // expected average: plain integer division
  function automatic longint exp_avg(input int idx);
    return bsum[idx] / NS;
  endfunction

  // converter model: answers each request after 1..4 cycles
  initial begin
    forever begin
      @(negedge clk);
      adc_valid = 1'b0;
      if (rst_n && adc_req) begin
        automatic int ph  = sw_neg_en ? 1 : 0;
        automatic int ch  = adc_ch ? 1 : 0;
        automatic int lat = $urandom_range(0, 3);
        chk(sw_pos_en ^ sw_neg_en, "R6 request with exactly one switch closed", sw_pos_en + sw_neg_en, 1);
        chk(ch == rq[ph] % 2, "R6 channel alternation", ch, rq[ph] % 2);
        rq[ph]++;
        for (int i = 0; i <= lat; i++) begin
          @(negedge clk);
          if (adc_req) chk(1'b0, "R7 request while outstanding", 1, 0);
        end
        adc_data  = gen_data();
        adc_valid = 1'b1;
        bsum[ph*2+ch] += longint'(adc_data);
        bcnt[ph*2+ch]++;
      end
    end
  end

  // interval and done monitor
  initial begin
    automatic bit pp = 0, pn = 0, pn2 = 0, pd = 0;
    automatic bit sp_open = 0, sn_open = 0, dd_open = 0;
    automatic int sp_cnt = 0, sn_cnt = 0, dd_cnt = 0;
    automatic logic [DW-1:0] pa [4] = '{default: '0};
    forever begin
      @(negedge clk);
      if (rst_n) begin
        chk(!(sw_pos_en && sw_neg_en), "R5 enables exclusive", sw_pos_en + sw_neg_en, 1);
        if (sw_pos_en && !pp) begin sp_cnt = 0; sp_open = 1; end
        if (sw_pos_en && sp_open) begin
          if (adc_req) begin meas_sp = sp_cnt; sp_open = 0; end else sp_cnt++;
        end
        if (sw_neg_en && !pn) begin sn_cnt = 0; sn_open = 1; end
        if (sw_neg_en && sn_open) begin
          if (adc_req) begin meas_sn = sn_cnt; sn_open = 0; end else sn_cnt++;
        end
        if (!sw_pos_en && pp) begin dd_cnt = 0; dd_open = 1; end
        if (dd_open) begin
          if (sw_neg_en) begin meas_dead = dd_cnt; dd_open = 0; end else dd_cnt++;
        end
        if (done) begin
          done_seen++;
          chk(!pd, "R9 done single cycle", pd, 0);
          chk(!pn && pn2, "R9 done one cycle after negative switch opens", {pn2, pn}, 2);
        end else begin
          chk(avg_iso_pos == pa[0] && avg_bus_pos == pa[1] &&
              avg_iso_neg == pa[2] && avg_bus_neg == pa[3],
              "R9 averages hold between done pulses", avg_iso_pos, pa[0]);
        end
      end
      pn2 = pn; pp = sw_pos_en; pn = sw_neg_en; pd = done;
      pa[0] = avg_iso_pos; pa[1] = avg_bus_pos; pa[2] = avg_iso_neg; pa[3] = avg_bus_neg;
    end
  end

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog R9 run never completed actual=0 expected=1");
    finish_run();
  end

  task automatic pulse_start();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic prog(input int s, input int d);
    @(negedge clk);
    settle_wr = 1'b1; settle_val = CW'(s);
    dead_wr   = 1'b1; dead_val   = CW'(d);
    @(negedge clk);
    settle_wr = 1'b0; dead_wr = 1'b0;
    cur_settle = s; cur_dead = d;
  endtask

  task automatic run_cycle(input int mode, input bit midwr, input int sn_new, input bit busy_start);
    automatic int exp_sp = eff(cur_settle);
    automatic int exp_dd = eff(cur_dead);
    automatic int exp_sn;
    automatic int t = 0;
    for (int i = 0; i < 4; i++) begin bsum[i] = 0; bcnt[i] = 0; end
    rq[0] = 0; rq[1] = 0;
    meas_sp = -1; meas_sn = -1; meas_dead = -1;
    data_mode = mode;
    pulse_start();
    chk(sw_pos_en, "R2 positive switch closes after start", sw_pos_en, 1);
    while (sw_pos_en && t < 20000) begin @(negedge clk); t++; end
    if (midwr) begin
      settle_wr = 1'b1; settle_val = CW'(sn_new);
      @(negedge clk);
      settle_wr = 1'b0;
      cur_settle = sn_new;
    end
    if (busy_start) begin
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    exp_sn = eff(cur_settle);
    t = 0;
    while (!done && t < 20000) begin @(negedge clk); t++; end
    chk(done, "R9 done reached", done, 1);
    chk(meas_sp == exp_sp, "R2 positive settle cycles", meas_sp, exp_sp);
    chk(meas_dead == exp_dd, "R4 break-before-make cycles", meas_dead, exp_dd);
    chk(meas_sn == exp_sn, midwr ? "R3 settle write during gap" : "R2 negative settle cycles", meas_sn, exp_sn);
    for (int i = 0; i < 4; i++)
      chk(bcnt[i] == NS, "R6 samples per channel and phase", bcnt[i], NS);
    chk(longint'(avg_iso_pos) == exp_avg(0), "R8 iso positive average", avg_iso_pos, exp_avg(0));
    chk(longint'(avg_bus_pos) == exp_avg(1), "R8 bus positive average", avg_bus_pos, exp_avg(1));
    chk(longint'(avg_iso_neg) == exp_avg(2), "R8 iso negative average", avg_iso_neg, exp_avg(2));
    chk(longint'(avg_bus_neg) == exp_avg(3), "R8 bus negative average", avg_bus_neg, exp_avg(3));
    repeat (3) @(negedge clk);
    chk(!sw_pos_en && !sw_neg_en, "R10 no restart from start during run", sw_pos_en, 0);
  endtask

  initial begin
    automatic bit seen_p = 0;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk(!sw_pos_en && !sw_neg_en && !adc_req && !done, "R1 reset outputs low",
        {sw_pos_en, sw_neg_en, adc_req, done}, 0);
    rst_n = 1'b1;
    // start held during warm-up (200 cycles) must be ignored
    start = 1'b1;
    for (int i = 0; i < 150; i++) begin @(negedge clk); if (sw_pos_en) seen_p = 1; end
    start = 1'b0;
    for (int i = 0; i < 80; i++) begin @(negedge clk); if (sw_pos_en) seen_p = 1; end
    chk(!seen_p, "R1 start ignored during warm-up", seen_p, 0);

    // reset-default intervals: 500 settle, 400 gap
    run_cycle(0, 1'b0, 0, 1'b0);
    chk(meas_sp == 500 && meas_dead == 400, "R3 reset defaults", meas_sp, 500);

    // zero register values act as one; full-scale samples
    prog(0, 2);
    run_cycle(1, 1'b0, 0, 1'b1);

    // settle rewritten during the gap; zero samples; start while busy
    prog(10, 30);
    run_cycle(2, 1'b1, 5, 1'b1);

    // abort during the negative phase
    begin
      automatic logic [DW-1:0] keep [4];
      automatic int d0;
      automatic int t = 0;
      keep[0] = avg_iso_pos; keep[1] = avg_bus_pos; keep[2] = avg_iso_neg; keep[3] = avg_bus_neg;
      prog(20, 20);
      pulse_start();
      while (!sw_neg_en && t < 20000) begin @(negedge clk); t++; end
      repeat (25) @(negedge clk);
      d0 = done_seen;
      abort = 1'b1;
      @(negedge clk);
      abort = 1'b0;
      chk(!sw_pos_en && !sw_neg_en, "R11 abort opens switches", {sw_pos_en, sw_neg_en}, 0);
      repeat (300) @(negedge clk);
      chk(done_seen == d0, "R11 no done after abort", done_seen - d0, 0);
      chk(avg_iso_pos == keep[0] && avg_bus_pos == keep[1] &&
          avg_iso_neg == keep[2] && avg_bus_neg == keep[3],
          "R11 averages unchanged by abort", avg_iso_pos, keep[0]);
    end
    run_cycle(0, 1'b0, 0, 1'b0);

    // constrained random runs
    for (int n = 0; n < 25; n++) begin
      automatic int  s  = $urandom_range(0, 40);
      automatic int  d  = $urandom_range(2, 40);
      automatic bit  mw = 1'($urandom_range(0, 1));
      automatic bit  bs = 1'($urandom_range(0, 1));
      automatic int  sn = $urandom_range(0, 40);
      automatic int  md = ($urandom_range(0, 1) == 1) ? 3 : 0;
      prog(s, d);
      run_cycle(md, mw, sn, bs);
    end

    finish_run();
  end

endmodule